// File: doc/BRIEF.md
# DMA Channel Chaining Controller

This block links logical DMA channels into chains. Each of the 32 channels holds a small link word and a control word. The link word names a successor channel and carries a link-enable flag. The control word carries the channel enable and a synchronization-mode flag. The data mover itself is outside the block. It sees this block only through a per-channel start pulse (out) and a per-channel completion pulse (in). When an enabled channel completes and its link is on, the block retires that channel and enables its successor on the same clock edge.

Software enables only the head of a chain; the other members start disabled. An unsynchronized channel is launched as soon as it is enabled. A hardware-synchronized channel waits until its request line goes high. Pointing the last channel back at the first makes a loop, and clearing the link flag of the final channel ends it on the next pass.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, `enableOut`, `busyOut` and `startOut` are all zero and every link word is cleared (link off, successor 0).
- R2: A write with `cfgWrSel`=0 loads the control word of channel `cfgWrChan`: bit 7 is the enable and bit 0 selects synchronized mode (1) or free-running mode (0). Writing the enable as 0 also clears that channel's busy flag.
- R3: A write with `cfgWrSel`=1 loads the link word of channel `cfgWrChan`: bits [4:0] are the successor number and bit 15 is the link enable. A write is accepted in any cycle. A completion in the same cycle still uses the old link word.
- R4: `startOut[i]` is high in any cycle where channel i is enabled, not busy, and either free-running or seeing `reqLine[i]` high. It is combinational from the current state and `reqLine`.
- R5: A start sets the channel's busy flag on the next edge, so each activation gives exactly one single-cycle start pulse. Busy holds until completion or a software disable.
- R6: A synchronized channel that is enabled raises no start while its request line is low.
- R7: A completion pulse on an enabled channel clears that channel's enable and busy flags on the next edge.
- R8: If the completing channel's link is on, the successor is enabled (and not busy) on that same edge. A channel linked to itself therefore restarts.
- R9: A completing channel whose link is off enables no other channel, so the chain ends there.
- R10: A completion pulse on a channel that is not enabled has no effect.
- R11: On one channel in one cycle, enabling as a successor beats clearing by completion, and clearing by completion beats a software control write.
- R12: A looping chain keeps cycling until the link of its final channel is cleared. After that it stops when that channel next completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrSel | input | 1 | 0 selects the control word, 1 selects the link word |
| cfgWrChan | input | 5 | Channel addressed by the write |
| cfgWrData | input | 16 | Write data |
| reqLine | input | 32 | Per-channel hardware request levels |
| doneIn | input | 32 | Per-channel completion pulses from the data mover |
| startOut | output | 32 | Per-channel start pulses to the data mover |
| enableOut | output | 32 | Per-channel enable state |
| busyOut | output | 32 | Per-channel in-flight state |

## Verification
The bench targets the following cases:
- A completion racing a link rewrite. A design that read the new link word would enable the wrong successor.
- A completion racing a software write on the same channel, and a successor enable racing a software disable. Wrong precedence leaves a stray enabled channel, or drops a chain member.
- A self-linked channel. A design that let the clear win would stall it.
- A stray completion on an idle channel. A design that did not gate it would spawn a successor.
- A synchronized successor whose request line rises late. A design that ignored the mode would start it early.
- Breaking a loop. A design that cached the link would never stop.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  parameter int unsigned CHAN_NUM = 32;
  parameter int unsigned CFG_W = 16;
  localparam int unsigned CHAN_W = $clog2(CHAN_NUM);
  localparam int unsigned LINK_EN_BIT = 15;
  localparam int unsigned CTRL_EN_BIT = 7;
  localparam int unsigned CTRL_SYNC_BIT = 0;

  typedef logic [CHAN_NUM-1:0] chanVec_t;

  typedef struct packed {
    logic              linkWr;
    logic [CHAN_W-1:0] wrChan;
    logic [CFG_W-1:0]  wrData;
    chanVec_t          retire;
  } chainStrobe_t;
endpackage

// File: rtl/chain_link_path.sv
module chain_link_path
  import dma_chain_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  chainStrobe_t strobe,
  output chanVec_t     succSet
);
  logic [CHAN_W-1:0] nextQ [CHAN_NUM];
  chanVec_t          linkEnQ;
  chanVec_t          hitVec [CHAN_NUM];

  for (genvar i = 0; i < CHAN_NUM; i++) begin : g_link
    always_ff @(posedge clk) begin
      if (!rstN) begin
        nextQ[i]   <= '0;
        linkEnQ[i] <= 1'b0;
      end else if (strobe.linkWr && strobe.wrChan == CHAN_W'(i)) begin
        nextQ[i]   <= strobe.wrData[CHAN_W-1:0];
        linkEnQ[i] <= strobe.wrData[LINK_EN_BIT];
      end
    end
    assign hitVec[i] = (strobe.retire[i] && linkEnQ[i]) ?
                       (chanVec_t'(1) << nextQ[i]) : '0;
  end

  always_comb begin
    succSet = '0;
    for (int i = 0; i < CHAN_NUM; i++) succSet |= hitVec[i];
  end

  // R9: a completion with link off enables nothing
  assert_no_unlinked_succ_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.retire & linkEnQ) == '0) |-> (succSet == '0));
  // R8: never more successors than linked completions
  assert_succ_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(succSet) <= $countones(strobe.retire & linkEnQ));
endmodule

// File: rtl/chain_ctrl_fsm.sv
module chain_ctrl_fsm
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgWrSel,
  input  logic [CHAN_W-1:0] cfgWrChan,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  chanVec_t          reqLine,
  input  chanVec_t          doneIn,
  input  chanVec_t          succSet,
  output chainStrobe_t      strobe,
  output chanVec_t          startOut,
  output chanVec_t          enableOut,
  output chanVec_t          busyOut
);
  chanVec_t enQ, busyQ, syncQ;
  chanVec_t enD, busyD, syncD;
  chanVec_t ctrlHit, retire, startNow;

  assign ctrlHit  = (cfgWrEn && !cfgWrSel) ? (chanVec_t'(1) << cfgWrChan) : '0;
  assign retire   = doneIn & enQ;
  assign startNow = enQ & ~busyQ & (~syncQ | reqLine);

  assign strobe.linkWr = cfgWrEn && cfgWrSel;
  assign strobe.wrChan = cfgWrChan;
  assign strobe.wrData = cfgWrData;
  assign strobe.retire = retire;

  always_comb begin
    enD   = enQ;
    busyD = busyQ | startNow;
    syncD = syncQ;
    for (int i = 0; i < CHAN_NUM; i++) begin
      if (ctrlHit[i]) begin
        enD[i]   = cfgWrData[CTRL_EN_BIT];
        syncD[i] = cfgWrData[CTRL_SYNC_BIT];
        if (!cfgWrData[CTRL_EN_BIT]) busyD[i] = 1'b0;
      end
      if (retire[i]) begin
        enD[i]   = 1'b0;
        busyD[i] = 1'b0;
      end
      if (succSet[i]) begin
        enD[i]   = 1'b1;
        busyD[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= '0;
      busyQ <= '0;
      syncQ <= '0;
    end else begin
      enQ   <= enD;
      busyQ <= busyD;
      syncQ <= syncD;
    end
  end

  assign startOut  = startNow;
  assign enableOut = enQ;
  assign busyOut   = busyQ;

  // R8: a successor chosen by the link path is enabled and idle next cycle
  assert_succ_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|succSet) |=> (($past(succSet) & ~(enQ & ~busyQ)) == '0));
  // R7: a completed channel that is not its own successor is disabled
  assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((|(retire & ~succSet)) && !cfgWrEn) |=> (($past(retire & ~succSet) & (enQ | busyQ)) == '0));
  // R10: a stray completion enables nothing
  assert_stray_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((|(doneIn & ~enQ & ~succSet)) && !cfgWrEn) |=> (($past(doneIn & ~enQ & ~succSet) & enQ) == '0));
  // R5: a start is followed by busy, so it cannot repeat
  assert_start_then_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((|(startOut & ~doneIn & ~succSet)) && !cfgWrEn) |=>
      (($past(startOut & ~doneIn & ~succSet) & ~busyQ) == '0));
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgWrSel,
  input  logic [CHAN_W-1:0]   cfgWrChan,
  input  logic [CFG_W-1:0]    cfgWrData,
  input  logic [CHAN_NUM-1:0] reqLine,
  input  logic [CHAN_NUM-1:0] doneIn,
  output logic [CHAN_NUM-1:0] startOut,
  output logic [CHAN_NUM-1:0] enableOut,
  output logic [CHAN_NUM-1:0] busyOut
);
  chainStrobe_t strobe;
  chanVec_t     succSet;

  chain_ctrl_fsm u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrChan(cfgWrChan), .cfgWrData(cfgWrData), .reqLine(reqLine),
    .doneIn(doneIn), .succSet(succSet), .strobe(strobe),
    .startOut(startOut), .enableOut(enableOut), .busyOut(busyOut)
  );

  chain_link_path u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .succSet(succSet)
  );
endmodule

// File: tb/dma_chain_ctrl_tb.sv
module dma_chain_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgWrSel = 1'b0;
  logic [4:0]  cfgWrChan = '0;
  logic [15:0] cfgWrData = '0;
  logic [31:0] reqLine = '0, doneIn = '0;
  logic [31:0] startOut, enableOut, busyOut;

  int nChecks = 0, nFails = 0;

  dma_chain_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrChan(cfgWrChan), .cfgWrData(cfgWrData), .reqLine(reqLine),
    .doneIn(doneIn), .startOut(startOut), .enableOut(enableOut), .busyOut(busyOut)
  );

  always #5 clk = ~clk;

  // behavioural reference
  bit mEn[32], mBusy[32], mSync[32], mLink[32];
  int mNext[32];

  function automatic logic [31:0] expStart();
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++)
      v[i] = mEn[i] && !mBusy[i] && (!mSync[i] || reqLine[i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) begin
        mEn[i] = 0; mBusy[i] = 0; mSync[i] = 0; mLink[i] = 0; mNext[i] = 0;
      end
    end else begin
      bit nEn[32], nBusy[32], setIt[32];
      logic [31:0] st;
      st = expStart();
      for (int i = 0; i < 32; i++) begin
        nEn[i] = mEn[i]; nBusy[i] = mBusy[i] || st[i]; setIt[i] = 0;
      end
      for (int i = 0; i < 32; i++)
        if (doneIn[i] && mEn[i] && mLink[i]) setIt[mNext[i]] = 1;
      if (cfgWrEn && !cfgWrSel) begin
        nEn[cfgWrChan] = cfgWrData[7];
        mSync[cfgWrChan] = cfgWrData[0];
        if (!cfgWrData[7]) nBusy[cfgWrChan] = 0;
      end
      for (int i = 0; i < 32; i++) begin
        if (doneIn[i] && mEn[i]) begin nEn[i] = 0; nBusy[i] = 0; end
        if (setIt[i]) begin nEn[i] = 1; nBusy[i] = 0; end
      end
      if (cfgWrEn && cfgWrSel) begin
        mNext[cfgWrChan] = int'(cfgWrData[4:0]);
        mLink[cfgWrChan] = cfgWrData[15];
      end
      for (int i = 0; i < 32; i++) begin mEn[i] = nEn[i]; mBusy[i] = nBusy[i]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      logic [31:0] eE, eB;
      for (int i = 0; i < 32; i++) begin eE[i] = mEn[i]; eB[i] = mBusy[i]; end
      chk(enableOut === eE, "R8 enable state", enableOut, eE);
      chk(busyOut === eB, "R5 busy state", busyOut, eB);
      chk(startOut === expStart(), "R4 start pulses", startOut, expStart());
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    cfgWrEn = 0; doneIn = '0;
  endtask
  task automatic wrCtrl(input int ch, input bit en, input bit sy);
    tick();
    cfgWrEn = 1; cfgWrSel = 0; cfgWrChan = 5'(ch);
    cfgWrData = '0; cfgWrData[7] = en; cfgWrData[0] = sy;
  endtask
  task automatic wrLink(input int ch, input int nxt, input bit ln);
    tick();
    cfgWrEn = 1; cfgWrSel = 1; cfgWrChan = 5'(ch);
    cfgWrData = '0; cfgWrData[4:0] = 5'(nxt); cfgWrData[15] = ln;
  endtask
  task automatic done(input int ch);
    tick();
    doneIn = 32'd1 << ch;
  endtask

  initial begin
    #1_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    chk(enableOut == 0 && busyOut == 0 && startOut == 0, "R1 reset state", enableOut | busyOut | startOut, 0);

    // terminating chain 0 -> 1 -> 2, all free-running
    wrLink(0, 1, 1); wrLink(1, 2, 1); wrLink(2, 0, 0);
    wrCtrl(0, 1, 0); tick();
    chk(startOut[0] == 1, "R2 R4 head starts", startOut, 32'h1);
    tick();
    chk(busyOut[0] == 1 && startOut[0] == 0, "R5 single pulse", startOut, 0);
    done(0); tick();
    chk(enableOut == 32'h2 && startOut == 32'h2, "R7 R8 successor enabled", enableOut, 32'h2);
    tick(); done(1); tick(); tick(); done(2); tick();
    chk(enableOut == 0, "R9 chain ends", enableOut, 0);

    // synchronized successor 4 -> 5
    wrCtrl(5, 0, 1); wrLink(4, 5, 1); wrCtrl(4, 1, 0);
    tick(); tick(); done(4); tick(); tick(); tick();
    chk(enableOut[5] == 1 && startOut[5] == 0 && busyOut[5] == 0, "R6 waits for request", startOut, 0);
    reqLine[5] = 1; #1;
    chk(startOut[5] == 1, "R6 start on request", startOut, 32'h20);
    tick(); reqLine[5] = 0; done(5); tick();
    chk(enableOut == 0, "R7 sync channel retired", enableOut, 0);

    // stray completion
    wrLink(10, 11, 1); done(10); tick(); tick();
    chk(enableOut == 0, "R10 stray done ignored", enableOut, 0);

    // self loop
    wrLink(12, 12, 1); wrCtrl(12, 1, 0); tick(); tick(); done(12); tick();
    chk(enableOut[12] == 1 && busyOut[12] == 0 && startOut[12] == 1, "R8 self link restarts", startOut, 32'h1000);
    wrLink(12, 12, 0); tick(); done(12); tick();
    chk(enableOut == 0, "R9 self loop ended", enableOut, 0);

    // precedence: done beats software enable on same channel
    wrCtrl(3, 1, 0); tick(); tick();
    tick(); cfgWrEn = 1; cfgWrSel = 0; cfgWrChan = 5'd3; cfgWrData = 16'h0080; doneIn = 32'h8;
    tick();
    chk(enableOut[3] == 0, "R11 done beats write", enableOut, 0);
    // precedence: successor beats software disable
    wrLink(20, 21, 1); wrCtrl(20, 1, 0); tick(); tick();
    tick(); cfgWrEn = 1; cfgWrSel = 0; cfgWrChan = 5'd21; cfgWrData = 16'h0000; doneIn = 32'h1 << 20;
    tick();
    chk(enableOut == (32'h1 << 21), "R11 successor beats disable", enableOut, 32'h1 << 21);
    tick(); done(21); tick();

    // link rewrite racing completion uses old link
    wrLink(14, 15, 1); wrCtrl(14, 1, 0); tick(); tick();
    tick(); cfgWrEn = 1; cfgWrSel = 1; cfgWrChan = 5'd14; cfgWrData = 16'h8010; doneIn = 32'h1 << 14;
    tick();
    chk(enableOut == (32'h1 << 15), "R3 old link used", enableOut, 32'h1 << 15);
    tick(); done(15); tick();
    wrCtrl(14, 1, 0); tick(); tick(); done(14); tick();
    chk(enableOut == (32'h1 << 16), "R3 new link used", enableOut, 32'h1 << 16);
    tick(); done(16); tick();

    // looping chain 7 -> 8 -> 7
    wrLink(7, 8, 1); wrLink(8, 7, 1); wrCtrl(7, 1, 0);
    for (int r = 0; r < 3; r++) begin
      tick(); tick(); done(7); tick(); tick(); done(8); tick();
      chk(enableOut == (32'h1 << 7), "R12 loop wraps", enableOut, 32'h80);
    end
    wrLink(8, 7, 0);
    tick(); tick(); done(7); tick(); tick(); done(8); tick(); tick();
    chk(enableOut == 0, "R12 loop stopped", enableOut, 0);

    repeat (3) tick();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule